// File: doc/BRIEF.md
# Interrupt Status Unit with Deferred Completion

This block keeps a storage controller's interrupt status byte, interrupt cause byte and sequence step, and drives one level-sensitive interrupt line toward the host. Logic elsewhere in the controller sends a raise request that carries a cause code, a sequence step and extra status bits. It also sends command-completion events that carry a status byte. The host clears the interrupt by reading the cause register. That read is destructive: the host gets the old cause in the read cycle, and from the next cycle the cause is zero and the line is low.

A completion can arrive while an earlier interrupt is still waiting for the host. In that case the completion is not reported at once. Its status byte is parked in a one-entry slot, and the completion is replayed at the same clock edge that applies the host's cause read. The host therefore sees every completion as its own interrupt, after the one it is servicing.

The block also keeps the FIFO flag count, the transfer count and configuration register 1. A completion report clears the first two, and configuration register 1 has a non-zero reset value.

Top module: `intr_status_unit`

## Requirements
- R1: A raise request sets the pending bit (status bit 7) and the irq output at the next clock edge. It loads the cause and sequence step from the request and ORs the request's seven status bits into status bits 6..0.
- R2: A raise request while the pending bit is already set keeps irq high with no low cycle in between, and the cause and sequence step take the new request's values.
- R3: The cause value presented in the cycle of a host cause read is the old cause. After that edge the cause is 0, status bit 4 (terminal count) is 0, the sequence step is 4 (command done), and the pending bit and irq are low.
- R4: A completion while nothing is pending is reported at the next edge. The status byte output takes the completion status, the status register becomes 8'h83 (pending plus phase code 3 in bits 2..0), the cause becomes 8'h10 (bus service), and the sequence step, FIFO flags and transfer count become 0.
- R5: A completion while the pending bit is set leaves status, cause, sequence step, flags, transfer count, status byte and irq unchanged at that edge.
- R6: A host cause read while a completion is parked applies the R4 report with the parked status at the same edge, so irq stays high. A further read with no parked completion then leaves irq low.
- R7: When a second completion arrives while one is already parked, the newer status byte replaces the older one.
- R8: The soft reset input clears every register, sets configuration register 1 to 8'h07, drops irq and discards a parked completion.
- R9: A synchronous active-low rst_n has the same effect as the soft reset.
- R10: The configuration, FIFO flag and transfer count load strobes write their values at the next edge.
- R11: When several strobes share a cycle, their effects apply in this order: loads, then the host read (with any replay), then the completion, then the raise request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Controller soft reset strobe |
| cfg1_we | input | 1 | Configuration register 1 write strobe |
| cfg1_wdata | input | 8 | Configuration register 1 write value |
| tc_load | input | 1 | Transfer count load strobe |
| tc_value | input | TC_W | Transfer count load value |
| flags_load | input | 1 | FIFO flag count load strobe |
| flags_value | input | FL_W | FIFO flag count load value |
| ev_raise | input | 1 | Interrupt raise request |
| ev_cause | input | 8 | Cause code for the raise request |
| ev_seq | input | 3 | Sequence step for the raise request |
| ev_stat | input | 7 | Status bits ORed in by the raise request |
| cmpl_req | input | 1 | Command completion event |
| cmpl_status | input | 8 | Status byte of the completion |
| cause_rd | input | 1 | Host read strobe of the cause register |
| irq | output | 1 | Level interrupt output |
| stat_reg | output | 8 | Interrupt status register |
| cause_reg | output | 8 | Interrupt cause register |
| seq_reg | output | 3 | Sequence step register |
| flags_reg | output | FL_W | FIFO flag count |
| tc_reg | output | TC_W | Transfer count |
| cfg1_reg | output | 8 | Configuration register 1 |
| status_byte | output | 8 | Last reported completion status |

## Verification
The assertions assume every strobe is a clean 0 or 1 from the first clock on. They also assume the bench holds rst_n low through the first edges, so nothing is judged before the registers have been cleared. Each timing property only applies when the competing strobes of R11 are idle in that cycle. For that reason the directed cases drive one strobe at a time and check each rule on its own. The random phase then mixes all strobes in the same cycles, and the bench's model applies them in the order given by R11.

// File: rtl/isr_pkg.sv
// Package: shared constants and field positions of the interrupt status unit.
// Assumes 8-bit status and cause registers and a 3-bit sequence step.
package isr_pkg;
    localparam int REG_W    = 8;
    localparam int SEQ_W    = 3;
    localparam int STAT_LOW = REG_W - 1;   // raise-request status bits below pending

    localparam int PEND_BIT = 7;           // interrupt pending flag
    localparam int TC_BIT   = 4;           // terminal count flag

    localparam logic [2:0]       PHASE_STATUS      = 3'd3;
    localparam logic [REG_W-1:0] CAUSE_BUS_SERVICE = 8'h10;
    localparam logic [SEQ_W-1:0] SEQ_CMD_DONE      = 3'd4;
    localparam logic [REG_W-1:0] CFG1_RESET        = 8'h07;
endpackage

// File: rtl/isr_step.sv
// Module: isr_step
// Purpose: combinational next-state logic. It applies one cycle's strobes in a
// fixed order: loads, host cause read (with replay of a parked completion),
// completion, raise request.
// Assumes the caller registers every output and handles both resets.
module isr_step
    import isr_pkg::*;
#(
    parameter int TC_W = 24,
    parameter int FL_W = 5
) (
    input  logic [REG_W-1:0] cur_stat,
    input  logic [REG_W-1:0] cur_cause,
    input  logic [SEQ_W-1:0] cur_seq,
    input  logic [FL_W-1:0]  cur_flags,
    input  logic [TC_W-1:0]  cur_tc,
    input  logic [REG_W-1:0] cur_sbyte,
    input  logic             held,
    input  logic [REG_W-1:0] held_status,
    input  logic             tc_load,
    input  logic [TC_W-1:0]  tc_value,
    input  logic             flags_load,
    input  logic [FL_W-1:0]  flags_value,
    input  logic             ev_raise,
    input  logic [REG_W-1:0] ev_cause,
    input  logic [SEQ_W-1:0] ev_seq,
    input  logic [STAT_LOW-1:0] ev_stat,
    input  logic             cmpl_req,
    input  logic [REG_W-1:0] cmpl_status,
    input  logic             cause_rd,
    output logic [REG_W-1:0] nxt_stat,
    output logic [REG_W-1:0] nxt_cause,
    output logic [SEQ_W-1:0] nxt_seq,
    output logic [FL_W-1:0]  nxt_flags,
    output logic [TC_W-1:0]  nxt_tc,
    output logic [REG_W-1:0] nxt_sbyte,
    output logic             take,
    output logic             replay,
    output logic             irq_set,
    output logic             irq_clr
);
    localparam logic [REG_W-1:0] STAT_REPORT =
        REG_W'((1 << PEND_BIT) | int'(PHASE_STATUS));

    // Ordered evaluation of this cycle's strobes.
    always_comb begin
        nxt_stat  = cur_stat;
        nxt_cause = cur_cause;
        nxt_seq   = cur_seq;
        nxt_flags = flags_load ? flags_value : cur_flags;
        nxt_tc    = tc_load ? tc_value : cur_tc;
        nxt_sbyte = cur_sbyte;
        take      = 1'b0;
        replay    = 1'b0;

        if (cause_rd) begin
            nxt_cause         = '0;
            nxt_stat[TC_BIT]  = 1'b0;
            nxt_stat[PEND_BIT] = 1'b0;
            nxt_seq           = SEQ_CMD_DONE;
            if (held) begin
                replay    = 1'b1;
                nxt_stat  = STAT_REPORT;
                nxt_cause = CAUSE_BUS_SERVICE;
                nxt_seq   = '0;
                nxt_flags = '0;
                nxt_tc    = '0;
                nxt_sbyte = held_status;
            end
        end

        if (cmpl_req) begin
            if (nxt_stat[PEND_BIT]) begin
                take = 1'b1;
            end else begin
                nxt_stat  = STAT_REPORT;
                nxt_cause = CAUSE_BUS_SERVICE;
                nxt_seq   = '0;
                nxt_flags = '0;
                nxt_tc    = '0;
                nxt_sbyte = cmpl_status;
            end
        end

        if (ev_raise) begin
            nxt_stat[STAT_LOW-1:0] = nxt_stat[STAT_LOW-1:0] | ev_stat;
            nxt_stat[PEND_BIT]     = 1'b1;
            nxt_cause              = ev_cause;
            nxt_seq                = ev_seq;
        end
    end

    // Edge requests for the line driver: only on a change of the pending bit.
    always_comb begin
        irq_set = !cur_stat[PEND_BIT] &&  nxt_stat[PEND_BIT];
        irq_clr =  cur_stat[PEND_BIT] && !nxt_stat[PEND_BIT];
    end
endmodule

// File: rtl/isr_defer_slot.sv
// Module: isr_defer_slot
// Purpose: one-entry holding slot for a completion that arrived while an
// interrupt was pending. A new capture overwrites the held status.
// Assumes take and replay come from the same cycle's ordered evaluation.
module isr_defer_slot
    import isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             take,
    input  logic             replay,
    input  logic [REG_W-1:0] in_status,
    output logic             held,
    output logic [REG_W-1:0] held_status
);
    // Capture, consume or drop the parked completion.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            held        <= 1'b0;
            held_status <= '0;
        end else if (take) begin
            held        <= 1'b1;
            held_status <= in_status;
        end else if (replay) begin
            held        <= 1'b0;
        end
    end
endmodule

// File: rtl/isr_irq_line.sv
// Module: isr_irq_line
// Purpose: registered interrupt line driven by set and clear edge requests.
// Assumes set and clear never arrive in the same cycle.
module isr_irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic irq_set,
    input  logic irq_clr,
    output logic irq
);
    // Hold the line between edge requests.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            irq <= 1'b0;
        end else if (irq_set) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/intr_status_unit.sv
// Module: intr_status_unit
// Purpose: interrupt status, cause and sequence step registers with a
// destructive cause read and deferred reporting of completions.
// Assumes strobes are synchronous to clk; the host samples cause_reg in
// the cycle where it asserts cause_rd.
module intr_status_unit
    import isr_pkg::*;
#(
    parameter int TC_W = 24,
    parameter int FL_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                cfg1_we,
    input  logic [REG_W-1:0]    cfg1_wdata,
    input  logic                tc_load,
    input  logic [TC_W-1:0]     tc_value,
    input  logic                flags_load,
    input  logic [FL_W-1:0]     flags_value,
    input  logic                ev_raise,
    input  logic [REG_W-1:0]    ev_cause,
    input  logic [SEQ_W-1:0]    ev_seq,
    input  logic [STAT_LOW-1:0] ev_stat,
    input  logic                cmpl_req,
    input  logic [REG_W-1:0]    cmpl_status,
    input  logic                cause_rd,
    output logic                irq,
    output logic [REG_W-1:0]    stat_reg,
    output logic [REG_W-1:0]    cause_reg,
    output logic [SEQ_W-1:0]    seq_reg,
    output logic [FL_W-1:0]     flags_reg,
    output logic [TC_W-1:0]     tc_reg,
    output logic [REG_W-1:0]    cfg1_reg,
    output logic [REG_W-1:0]    status_byte
);
    logic [REG_W-1:0] nxt_stat, nxt_cause, nxt_sbyte, defer_status;
    logic [SEQ_W-1:0] nxt_seq;
    logic [FL_W-1:0]  nxt_flags;
    logic [TC_W-1:0]  nxt_tc;
    logic             take, replay, irq_set, irq_clr, defer_held;

    isr_step #(.TC_W(TC_W), .FL_W(FL_W)) u_step (
        .cur_stat    (stat_reg),
        .cur_cause   (cause_reg),
        .cur_seq     (seq_reg),
        .cur_flags   (flags_reg),
        .cur_tc      (tc_reg),
        .cur_sbyte   (status_byte),
        .held        (defer_held),
        .held_status (defer_status),
        .tc_load     (tc_load),
        .tc_value    (tc_value),
        .flags_load  (flags_load),
        .flags_value (flags_value),
        .ev_raise    (ev_raise),
        .ev_cause    (ev_cause),
        .ev_seq      (ev_seq),
        .ev_stat     (ev_stat),
        .cmpl_req    (cmpl_req),
        .cmpl_status (cmpl_status),
        .cause_rd    (cause_rd),
        .nxt_stat    (nxt_stat),
        .nxt_cause   (nxt_cause),
        .nxt_seq     (nxt_seq),
        .nxt_flags   (nxt_flags),
        .nxt_tc      (nxt_tc),
        .nxt_sbyte   (nxt_sbyte),
        .take        (take),
        .replay      (replay),
        .irq_set     (irq_set),
        .irq_clr     (irq_clr)
    );

    isr_defer_slot u_defer (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .take        (take),
        .replay      (replay),
        .in_status   (cmpl_status),
        .held        (defer_held),
        .held_status (defer_status)
    );

    isr_irq_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .irq_set  (irq_set),
        .irq_clr  (irq_clr),
        .irq      (irq)
    );

    // Register file update; both resets clear it, configuration 1 to its default.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            stat_reg    <= '0;
            cause_reg   <= '0;
            seq_reg     <= '0;
            flags_reg   <= '0;
            tc_reg      <= '0;
            status_byte <= '0;
            cfg1_reg    <= CFG1_RESET;
        end else begin
            stat_reg    <= nxt_stat;
            cause_reg   <= nxt_cause;
            seq_reg     <= nxt_seq;
            flags_reg   <= nxt_flags;
            tc_reg      <= nxt_tc;
            status_byte <= nxt_sbyte;
            if (cfg1_we) begin
                cfg1_reg <= cfg1_wdata;
            end
        end
    end
endmodule

// File: rtl/intr_status_unit_checker.sv
// Module: intr_status_unit_checker
// Purpose: temporal properties of the interrupt status unit, bound to its top.
// Assumes rst_n is held low across the first clock edges.
module intr_status_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       ev_raise,
    input logic       cmpl_req,
    input logic [7:0] cmpl_status,
    input logic       cause_rd,
    input logic       irq,
    input logic [7:0] stat_reg,
    input logic [7:0] cause_reg,
    input logic [2:0] seq_reg,
    input logic [7:0] cfg1_reg,
    input logic [7:0] status_byte,
    input logic       defer_held
);
    // The line driver and the status register must agree (R1).
    assert_line_tracks_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq == stat_reg[7]);

    // A repeated raise keeps the line high (R2).
    assert_no_reraise_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_raise && irq && !cause_rd && !soft_rst) |=> irq);

    // A plain cause read clears cause, terminal count and the line (R3).
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && !defer_held && !cmpl_req && !ev_raise && !soft_rst) |=>
        (cause_reg == 8'h00 && !irq && seq_reg == 3'd4 && !stat_reg[4]));

    // An idle completion is reported at once (R4).
    assert_direct_report_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_req && !irq && !cause_rd && !ev_raise && !soft_rst) |=>
        (irq && status_byte == $past(cmpl_status) && cause_reg == 8'h10));

    // A completion during a pending interrupt is only parked (R5).
    assert_parked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_req && irq && !cause_rd && !ev_raise && !soft_rst) |=>
        ($stable(cause_reg) && $stable(status_byte) && $stable(stat_reg) && defer_held));

    // A read with a parked completion replays it (R6).
    assert_replay_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd && defer_held && !cmpl_req && !ev_raise && !soft_rst) |=>
        (irq && !defer_held && cause_reg == 8'h10 && stat_reg[2:0] == 3'd3));

    // Soft reset drops everything (R8).
    assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq && !defer_held && cfg1_reg == 8'h07 && cause_reg == 8'h00));
endmodule

bind intr_status_unit intr_status_unit_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .ev_raise    (ev_raise),
    .cmpl_req    (cmpl_req),
    .cmpl_status (cmpl_status),
    .cause_rd    (cause_rd),
    .irq         (irq),
    .stat_reg    (stat_reg),
    .cause_reg   (cause_reg),
    .seq_reg     (seq_reg),
    .cfg1_reg    (cfg1_reg),
    .status_byte (status_byte),
    .defer_held  (defer_held)
);

// File: tb/intr_status_unit_bench.sv
// Bench: directed corner cases followed by seeded random strobes, compared
// every cycle against a model written from the requirements.
module intr_status_unit_bench;
    localparam int TC_W = 24;
    localparam int FL_W = 5;

    logic clk = 1'b0;
    logic rst_n, soft_rst, cfg1_we, tc_load, flags_load, ev_raise, cmpl_req, cause_rd;
    logic [7:0] cfg1_wdata, ev_cause, cmpl_status;
    logic [TC_W-1:0] tc_value;
    logic [FL_W-1:0] flags_value;
    logic [2:0] ev_seq;
    logic [6:0] ev_stat;
    logic irq;
    logic [7:0] stat_reg, cause_reg, cfg1_reg, status_byte;
    logic [2:0] seq_reg;
    logic [FL_W-1:0] flags_reg;
    logic [TC_W-1:0] tc_reg;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Model state.
    logic [7:0] m_stat, m_cause, m_cfg1, m_sbyte, m_hstat;
    logic [2:0] m_seq;
    logic [FL_W-1:0] m_flags;
    logic [TC_W-1:0] m_tc;
    logic m_held;

    always #10 clk = ~clk;

    intr_status_unit #(.TC_W(TC_W), .FL_W(FL_W)) u_intr_status_unit (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg1_we(cfg1_we), .cfg1_wdata(cfg1_wdata),
        .tc_load(tc_load), .tc_value(tc_value),
        .flags_load(flags_load), .flags_value(flags_value),
        .ev_raise(ev_raise), .ev_cause(ev_cause), .ev_seq(ev_seq), .ev_stat(ev_stat),
        .cmpl_req(cmpl_req), .cmpl_status(cmpl_status), .cause_rd(cause_rd),
        .irq(irq), .stat_reg(stat_reg), .cause_reg(cause_reg), .seq_reg(seq_reg),
        .flags_reg(flags_reg), .tc_reg(tc_reg), .cfg1_reg(cfg1_reg),
        .status_byte(status_byte)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset;
        m_stat = '0; m_cause = '0; m_seq = '0; m_flags = '0; m_tc = '0;
        m_sbyte = '0; m_cfg1 = 8'h07; m_held = 1'b0; m_hstat = '0;
    endtask

    // R4 report contents.
    task automatic model_report(input logic [7:0] s);
        m_stat = 8'h83; m_cause = 8'h10; m_seq = '0; m_flags = '0; m_tc = '0;
        m_sbyte = s;
    endtask

    // R11 ordering of one cycle.
    task automatic model_step;
        if (!rst_n || soft_rst) begin
            model_reset();
            return;
        end
        if (cfg1_we) m_cfg1 = cfg1_wdata;
        if (flags_load) m_flags = flags_value;
        if (tc_load) m_tc = tc_value;
        if (cause_rd) begin
            m_cause = '0; m_stat[4] = 1'b0; m_stat[7] = 1'b0; m_seq = 3'd4;
            if (m_held) begin
                m_held = 1'b0;
                model_report(m_hstat);
            end
        end
        if (cmpl_req) begin
            if (m_stat[7]) begin
                m_held = 1'b1; m_hstat = cmpl_status;
            end else begin
                model_report(cmpl_status);
            end
        end
        if (ev_raise) begin
            m_stat = m_stat | {1'b1, ev_stat};
            m_cause = ev_cause; m_seq = ev_seq;
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "irq", {31'd0, irq}, {31'd0, m_stat[7]});
        chk(tag, "stat", {24'd0, stat_reg}, {24'd0, m_stat});
        chk(tag, "cause", {24'd0, cause_reg}, {24'd0, m_cause});
        chk(tag, "seq", {29'd0, seq_reg}, {29'd0, m_seq});
        chk(tag, "flags", 32'(flags_reg), 32'(m_flags));
        chk(tag, "tc", 32'(tc_reg), 32'(m_tc));
        chk(tag, "cfg1", {24'd0, cfg1_reg}, {24'd0, m_cfg1});
        chk(tag, "status_byte", {24'd0, status_byte}, {24'd0, m_sbyte});
    endtask

    task automatic idle;
        soft_rst = 0; cfg1_we = 0; tc_load = 0; flags_load = 0;
        ev_raise = 0; cmpl_req = 0; cause_rd = 0;
    endtask

    // Inputs are already driven at a falling edge; clock once and compare.
    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        rst_n = 0; idle();
        cfg1_wdata = 0; tc_value = 0; flags_value = 0; ev_cause = 0; ev_seq = 0;
        ev_stat = 0; cmpl_status = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
        compare("R9");

        // R10: loads
        cfg1_we = 1; cfg1_wdata = 8'h5a; tc_load = 1; tc_value = 24'h123456;
        flags_load = 1; flags_value = 5'h1a;
        cycle("R10");

        // R1: first raise with terminal count bit
        ev_raise = 1; ev_cause = 8'h08; ev_seq = 3'd2; ev_stat = 7'h10;
        cycle("R1");
        chk("R1", "irq high", {31'd0, irq}, 32'd1);

        // R2: raise again while pending
        ev_raise = 1; ev_cause = 8'h20; ev_seq = 3'd1; ev_stat = 7'h01;
        cycle("R2");

        // R3: destructive read returns old cause
        chk("R3", "cause before read", {24'd0, cause_reg}, 32'h20);
        cause_rd = 1;
        cycle("R3");
        chk("R3", "irq low", {31'd0, irq}, 32'd0);

        // R4: completion while idle
        cmpl_req = 1; cmpl_status = 8'h02;
        cycle("R4");

        // R5: completion while pending is parked
        cmpl_req = 1; cmpl_status = 8'h44;
        cycle("R5");

        // R7: newer parked completion overwrites
        cmpl_req = 1; cmpl_status = 8'h55;
        cycle("R7");

        // R6: read replays the parked completion, then a read with none drops irq
        cause_rd = 1;
        cycle("R6");
        chk("R6", "replayed status", {24'd0, status_byte}, 32'h55);
        cause_rd = 1;
        cycle("R6");
        chk("R6", "irq after second read", {31'd0, irq}, 32'd0);

        // R8: soft reset discards a parked completion
        ev_raise = 1; ev_cause = 8'h08; ev_seq = 3'd3; ev_stat = 7'h00;
        cycle("R8");
        cmpl_req = 1; cmpl_status = 8'h77;
        cycle("R8");
        soft_rst = 1;
        cycle("R8");
        cause_rd = 1;
        cycle("R8");
        chk("R8", "no replay after soft reset", {24'd0, status_byte}, 32'h00);

        // R11: read, completion and raise in one cycle with nothing pending
        cause_rd = 1; cmpl_req = 1; cmpl_status = 8'h0c;
        ev_raise = 1; ev_cause = 8'h18; ev_seq = 3'd6; ev_stat = 7'h04;
        cycle("R11");

        // R11: random mix
        for (int i = 0; i < 600; i++) begin
            cause_rd    = ($urandom % 4) == 0;
            cmpl_req    = ($urandom % 4) == 0;
            ev_raise    = ($urandom % 4) == 0;
            soft_rst    = ($urandom % 64) == 0;
            cfg1_we     = ($urandom % 8) == 0;
            tc_load     = ($urandom % 8) == 0;
            flags_load  = ($urandom % 8) == 0;
            cfg1_wdata  = 8'($urandom);
            tc_value    = TC_W'($urandom);
            flags_value = FL_W'($urandom);
            ev_cause    = 8'($urandom);
            ev_seq      = 3'($urandom);
            ev_stat     = 7'($urandom);
            cmpl_status = 8'($urandom);
            cycle("R11");
        end

        // R9: hard reset in the middle of activity
        ev_raise = 1; ev_cause = 8'h08;
        cycle("R9");
        rst_n = 0;
        cycle("R9");
        rst_n = 1;
        compare("R9");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule